// File: doc/BRIEF.md
# Escaped Byte Stream Deframer

The deframer takes raw bytes from a parallel byte FIFO and recovers the messages framed inside them. One reserved code, the escape byte 0xA5, does all the framing work. 0xA5 then 0x02 opens a message and 0xA5 then 0x03 closes it. Inside a message, 0xA5 then 0xA5 stands for a single literal 0xA5. Whatever arrives between messages is thrown away.

The recovered payload leaves on a ready/valid byte stream. Each byte carries a start flag (the message header) and an end flag. This is the stream the shared message decoder reads, the same decoder the serial bus feeds. Every unescaped payload byte is also offered, at the moment it is consumed, on a checksum update strobe, so the checksum never sees framing or escape codes.

The serial bus outranks this path. While it is active, the FIFO is left unread and any message in progress is dropped.

To flag the final byte, the block keeps back the newest payload byte. It forwards that byte once the next payload byte or the end marker arrives.

Top module: `esc_deframer`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `crc_stb` and `frame_err` are 0 and `in_rd` is 0 even when `in_valid` is 1.
- R2: Outside a message, every byte except an escape byte followed by 0x02 is discarded. Such bytes produce no output beat and no checksum strobe.
- R3: Escape byte 0xA5 followed by 0x02 opens a message. The first payload byte after it leaves with `out_sof` = 1, and no other byte of that message does.
- R4: Escape byte 0xA5 followed by 0x03 inside a message closes it. The last payload byte leaves with `out_eof` = 1. Each payload byte is presented on the output in the cycle after the next payload byte or the close marker is consumed.
- R5: Inside a message, the pair 0xA5 0xA5 yields exactly one data byte of value 0xA5. Every other non-escape byte passes through unchanged.
- R6: `crc_stb` pulses for one cycle, in the cycle after each payload byte is consumed, with `crc_data` equal to the unescaped byte. It never pulses for a framing or escape code.
- R7: Inside a message, 0xA5 followed by any code other than 0x02, 0x03 or 0xA5 pulses `frame_err` for one cycle, in the cycle after the bad code is consumed. The held-back byte is discarded, no `out_eof` is given, and the bytes that follow are treated as outside a message.
- R8: 0xA5 0x02 inside a message restarts framing. The held-back byte is discarded, and the next payload byte carries `out_sof` = 1.
- R9: While `serial_active` is 1, `in_rd` stays 0 and the message in progress, including its held-back byte, is dropped. Once it falls, bytes are discarded until a new open sequence arrives.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_rd` is 0, and `out_data`, `out_sof` and `out_eof` hold their values.
- R11: A message with no payload (0xA5 0x02 0xA5 0x03) produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_active | input | 1 | Serial bus busy; aborts this path |
| in_valid | input | 1 | FIFO holds a byte (not empty) |
| in_data | input | 8 | Byte at the FIFO head |
| in_rd | output | 1 | Pop the FIFO head this cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | Byte is the first of a message |
| out_eof | output | 1 | Byte is the last of a message |
| crc_stb | output | 1 | Checksum update strobe |
| crc_data | output | 8 | Byte for the checksum update |
| frame_err | output | 1 | One-cycle pulse on a bad escape code |

## Verification
The assertions assume the input side behaves like a FIFO. `in_data` shows the head byte whenever `in_valid` is high, and `in_valid` never depends on `in_rd` in the same cycle. `out_ready` and `serial_active` are allowed to change freely. In the bench, the source is a queue whose head is presented while the queue is non-empty and which is popped only after a cycle with `in_rd` high. `out_ready` is driven either constantly high or as an irregular pattern that stalls the output. `serial_active` is raised only between byte bursts, so that the reference model and the design apply the abort at the same point in the byte stream.

// File: rtl/esc_deframer.sv
module esc_deframer #(
  parameter int unsigned DW  = 8,
  parameter logic [DW-1:0] ESC = 8'hA5,
  parameter logic [DW-1:0] SOM = 8'h02,
  parameter logic [DW-1:0] EOM = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serial_active,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_rd,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          crc_stb,
  output logic [DW-1:0] crc_data,
  output logic          frame_err
);

  logic          in_frame, esc_q, hold_v, hold_sof, sof_arm;
  logic [DW-1:0] hold_d;

  wire is_esc = (in_data == ESC);
  wire is_som = (in_data == SOM);
  wire is_eom = (in_data == EOM);

  assign in_rd = rst_n && in_valid && !serial_active && (!out_valid || out_ready);

  wire pay   = in_rd && in_frame && (esc_q ? is_esc : !is_esc);
  wire close = in_rd && in_frame && esc_q && is_eom;
  wire bad   = in_rd && in_frame && esc_q && !is_esc && !is_som && !is_eom;
  wire emit  = (pay || close) && hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      esc_q     <= 1'b0;
      hold_v    <= 1'b0;
      hold_sof  <= 1'b0;
      hold_d    <= '0;
      sof_arm   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      crc_stb   <= 1'b0;
      crc_data  <= '0;
      frame_err <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= hold_d;
        out_sof   <= hold_sof;
        out_eof   <= close;
      end
      crc_stb   <= pay;
      if (pay) crc_data <= in_data;
      frame_err <= bad;

      if (serial_active) begin
        in_frame <= 1'b0;
        esc_q    <= 1'b0;
        hold_v   <= 1'b0;
      end else if (in_rd) begin
        if (esc_q) begin
          esc_q <= is_esc && !in_frame;
          if (is_som) begin
            in_frame <= 1'b1;
            sof_arm  <= 1'b1;
            hold_v   <= 1'b0;
          end else if (in_frame && !is_esc) begin
            in_frame <= 1'b0;
            hold_v   <= 1'b0;
          end
        end else if (is_esc) begin
          esc_q <= 1'b1;
        end
        if (pay) begin
          hold_v   <= 1'b1;
          hold_d   <= in_data;
          hold_sof <= sof_arm;
          sof_arm  <= 1'b0;
        end
      end
    end
  end

  // R10
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_rd);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R9
  abort_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serial_active |-> !in_rd);

  // R6
  crc_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_stb |-> $past(in_rd));

  // R7
  err_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(in_rd) && !crc_stb));

endmodule

// File: tb/esc_deframer_tb.sv
module esc_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_active = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_rd;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof, out_eof, crc_stb, frame_err;
  logic [7:0] crc_data;

  always #4 clk = ~clk;

  esc_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .serial_active(serial_active),
    .in_valid(in_valid), .in_data(in_data), .in_rd(in_rd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .crc_stb(crc_stb),
    .crc_data(crc_data), .frame_err(frame_err)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] src_q[$];
  logic [9:0] exp_q[$];
  logic [7:0] crc_q[$];
  logic [7:0] cur_q[$];
  logic       cur_first = 1'b0;
  logic       first_arm = 1'b0;
  logic       m_in = 1'b0, m_esc = 1'b0;
  int         err_exp = 0;
  int n_out = 0, n_sof = 0, n_eof = 0, n_crc = 0, n_err = 0;
  logic pop_pend = 1'b0;
  logic stall_mode = 1'b0;
  logic prev_stall = 1'b0;
  logic [9:0] prev_out = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_payload(input logic [7:0] b);
    crc_q.push_back(b);
    if (cur_q.size() > 0) exp_q.push_back({cur_first, 1'b0, cur_q.pop_front()});
    cur_q.push_back(b);
    cur_first = first_arm;
    first_arm = 1'b0;
  endtask

  task automatic m_byte(input logic [7:0] b);
    if (!m_in) begin
      if (m_esc && b == 8'h02) begin
        m_in = 1'b1; m_esc = 1'b0; cur_q.delete(); first_arm = 1'b1;
      end else m_esc = (b == 8'hA5);
    end else if (m_esc) begin
      m_esc = 1'b0;
      if (b == 8'hA5) m_payload(b);
      else if (b == 8'h02) begin cur_q.delete(); first_arm = 1'b1; end
      else if (b == 8'h03) begin
        if (cur_q.size() > 0) exp_q.push_back({cur_first, 1'b1, cur_q.pop_front()});
        m_in = 1'b0;
      end else begin
        err_exp++; cur_q.delete(); m_in = 1'b0;
      end
    end else if (b == 8'hA5) m_esc = 1'b1;
    else m_payload(b);
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      // R1
      chk(!out_valid && !crc_stb && !frame_err && !in_rd, "R1 reset outputs",
          {out_valid, crc_stb, frame_err, in_rd}, 0);
    end else begin
      if (prev_stall)  // R10 hold
        chk(out_valid && {out_sof, out_eof, out_data} == prev_out, "R10 hold",
            {out_valid, out_sof, out_eof, out_data}, {1'b1, prev_out});
      if (out_valid && !out_ready) chk(!in_rd, "R10 no pop", in_rd, 0);
      if (serial_active) chk(!in_rd, "R9 no pop", in_rd, 0);
      if (out_valid && out_ready) begin
        n_out++; if (out_sof) n_sof++; if (out_eof) n_eof++;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected beat", out_data, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R5 data", out_data, e[7:0]);
          chk(out_sof == e[9], "R3 sof", out_sof, e[9]);
          chk(out_eof == e[8], "R4 eof", out_eof, e[8]);
        end
      end
      if (crc_stb) begin
        n_crc++;
        if (crc_q.size() == 0) chk(1'b0, "R6 unexpected strobe", crc_data, 0);
        else begin
          logic [7:0] c;
          c = crc_q.pop_front();
          chk(crc_data == c, "R6 crc byte", crc_data, c);
        end
      end
      if (frame_err) begin
        n_err++;
        chk(err_exp > 0, "R7 unexpected error", 1, 0);
        if (err_exp > 0) err_exp--;
      end
      if (serial_active) begin
        m_in = 1'b0; m_esc = 1'b0; cur_q.delete();
      end else if (in_rd) begin
        m_byte(in_data);
        pop_pend = 1'b1;
      end
    end
    prev_stall = rst_n && out_valid && !out_ready;
    prev_out = {out_sof, out_eof, out_data};
  end

  always @(posedge clk) begin
    #1;
    if (pop_pend && src_q.size() > 0) void'(src_q.pop_front());
    pop_pend = 1'b0;
    in_valid = (src_q.size() > 0);
    in_data = (src_q.size() > 0) ? src_q[0] : 8'h00;
    out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic pb(input logic [7:0] b);
    src_q.push_back(b);
  endtask

  task automatic settle();
    int n = 0;
    while ((src_q.size() > 0 || exp_q.size() > 0 || out_valid) && n < 2000) begin
      @(posedge clk); n++;
    end
    repeat (4) @(posedge clk);
  endtask

  int o0, c0, s0, e0, r0;
  task automatic mark();
    o0 = n_out; c0 = n_crc; s0 = n_sof; e0 = n_eof; r0 = n_err;
  endtask

  initial begin
    src_q.push_back(8'h11);
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 garbage outside any message
    mark();
    pb(8'h22); pb(8'hA5); pb(8'h07); pb(8'h33); pb(8'h03);
    settle();
    chk(n_out == o0 && n_crc == c0, "R2 discard", n_out - o0 + n_crc - c0, 0);

    // R3 R4 plain message
    mark();
    pb(8'hA5); pb(8'h02); pb(8'h10); pb(8'h20); pb(8'h30); pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out - o0 == 3 && n_sof - s0 == 1 && n_eof - e0 == 1, "R4 beats", n_out - o0, 3);

    // R5 escaped data, output stalls
    stall_mode = 1'b1;
    mark();
    pb(8'hA5); pb(8'h02); pb(8'hA5); pb(8'hA5); pb(8'h41); pb(8'hA5); pb(8'hA5);
    pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out - o0 == 3 && n_crc - c0 == 3, "R5 count", n_out - o0, 3);

    // R11 empty message, then single-byte message
    mark();
    pb(8'hA5); pb(8'h02); pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out == o0, "R11 empty", n_out - o0, 0);
    pb(8'hA5); pb(8'h02); pb(8'h99); pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out - o0 == 1 && n_sof - s0 == 1 && n_eof - e0 == 1, "R4 single", n_out - o0, 1);

    // R7 bad escape
    stall_mode = 1'b0;
    mark();
    pb(8'hA5); pb(8'h02); pb(8'h01); pb(8'h02); pb(8'hA5); pb(8'h55); pb(8'h03); pb(8'h04);
    settle();
    chk(n_err - r0 == 1 && n_out - o0 == 1 && n_eof == e0, "R7 drop", n_err - r0, 1);

    // R8 restart inside a message
    mark();
    pb(8'hA5); pb(8'h02); pb(8'h61); pb(8'h62); pb(8'hA5); pb(8'h02); pb(8'h63);
    pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out - o0 == 2 && n_sof - s0 == 2 && n_eof - e0 == 1, "R8 restart", n_sof - s0, 2);

    // R9 serial bus abort
    mark();
    pb(8'hA5); pb(8'h02); pb(8'h71); pb(8'h72);
    settle();
    @(posedge clk); #2 serial_active = 1'b1;
    pb(8'h73);
    repeat (5) @(posedge clk);
    #2 serial_active = 1'b0;
    pb(8'hA5); pb(8'h03);
    pb(8'hA5); pb(8'h02); pb(8'h74); pb(8'hA5); pb(8'h03);
    settle();
    chk(n_out - o0 == 2 && n_crc - c0 == 3 && n_eof - e0 == 1, "R9 abort", n_out - o0, 2);

    // end of run: model fully drained
    chk(exp_q.size() == 0 && crc_q.size() == 0 && err_exp == 0, "R6 drained",
        exp_q.size() + crc_q.size() + err_exp, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule